// File: doc/BRIEF.md
# Decode-Stage Next-PC Selection Unit

This unit chooses the address from which a five-stage 32-bit pipeline fetches next, and settles conditional branches while the branch is still in decode. Each cycle it looks at the instruction held in decode, the decode-stage PC, five decoded control flags (branch-if-equal, branch-if-not-equal, jump, jump-and-link, jump-register) and two register operands that have already been forwarded. From these it selects one of four next addresses. The first is the fetch PC plus four. The second is a PC-relative branch target. The third is a pseudo-direct jump target built from the upper PC bits and the instruction's index field. The fourth is a register-indirect target.

The unit holds the PC register, which keeps its value whenever the stall input is high. It also drives a redirect flag. The surrounding pipeline uses this flag to squash the instruction fetched on the wrong path. The flag is high in any cycle where a jump or a taken branch sits in decode and the pipe is not stalled. The unit further provides the return address that a jump-and-link writes to the link register. The operand comparison uses the forwarded values, so the branch decision already reflects results that have not yet reached the register file.

The reset input is asynchronous and active low. Its release passes through a two-flop synchronizer, so the PC leaves its reset value no earlier than the third rising edge after `rst_n` rises.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and until the internal synchronised reset releases, `pc_o` equals the parameter `RESET_PC` (default 32'h0040_0000).
- R2: With no control flag active, or with only a branch flag whose condition fails, and no stall, `next_pc_o` equals `pc_o + 4`, `redirect_o` is low, and `pc_o` takes that value on the next rising edge.
- R3: While `stall_i` is high, `pc_o` keeps its value, `next_pc_o` equals `pc_o`, and `redirect_o` is low, whatever the control flags are.
- R4: With `beq_i` set and `op_a_i == op_b_i`, the branch is taken. The target is `id_pc_i + 4 + (sign-extended id_instr_i[15:0] << 2)`.
- R5: With `bne_i` set and `op_a_i != op_b_i`, the branch is taken to the same target as R4. `beq_i` with unequal operands and `bne_i` with equal operands are not taken (R2 applies).
- R6: The branch offset in `id_instr_i[15:0]` is two's complement, so an offset with bit 15 set moves the target backwards.
- R7: With `j_i` or `jal_i` set, the target is `{id_pc_i[31:28], id_instr_i[25:0], 2'b00}`.
- R8: With `jr_i` set, the target is `op_a_i` unchanged.
- R9: When several flags are set, the priority is jump-register first, then jump and jump-and-link, then a taken branch, then the sequential address.
- R10: `redirect_o` is high exactly in the unstalled cycles in which R4, R5, R7 or R8 selects the target, and `pc_o` loads that target on the next edge.
- R11: `link_o` always equals `id_pc_i + 4`, the return address for a jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold the PC and suppress redirect |
| id_pc_i | input | 32 | PC of the instruction in decode |
| id_instr_i | input | 32 | Instruction word in decode |
| beq_i | input | 1 | Decode holds branch-if-equal |
| bne_i | input | 1 | Decode holds branch-if-not-equal |
| j_i | input | 1 | Decode holds a pseudo-direct jump |
| jal_i | input | 1 | Decode holds a jump-and-link |
| jr_i | input | 1 | Decode holds a register-indirect jump |
| op_a_i | input | 32 | Forwarded first register operand |
| op_b_i | input | 32 | Forwarded second register operand |
| pc_o | output | 32 | Current fetch PC |
| next_pc_o | output | 32 | Address loaded into the PC at the next edge |
| redirect_o | output | 1 | Taken branch or jump; flush the fetched instruction |
| link_o | output | 32 | Return address for jump-and-link |

## Verification
The bench targets the mixes of control flags that test the priority order. Jump-register is set together with jump and a taken branch, and jump is set together with a taken branch. A wrong order would send `pc_o` to the lower-priority target. Branch offsets with bit 15 set are applied; without sign extension they would land far forward of the decode PC. Branch flags are also driven with operand pairs that fail the condition, which would catch an inverted compare or a redirect that ignores the compare. Stalls are applied while jumps are in decode: a design that let a stalled redirect through would move `pc_o` or flush a good instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Source chosen for the next fetch address
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2,
    SRC_REG    = 2'd3
  } npc_src_e;

  // Decoded control flags for the instruction in decode
  typedef struct packed {
    logic beq;
    logic bne;
    logic jmp;
    logic jal;
    logic jreg;
  } npc_ctrl_t;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            equal
);

  logic [XLEN-1:0] bit_diff;

  // Per-bit difference, reduced to a single equality flag
  for (genvar gi = 0; gi < XLEN; gi++) begin : g_bit
    assign bit_diff[gi] = op_a[gi] ^ op_b[gi];
  end

  assign equal = ~|bit_diff;

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned IDX_W = 26
) (
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] id_pc,
  input  logic [XLEN-1:0] id_instr,
  output logic [XLEN-1:0] seq_tgt,
  output logic [XLEN-1:0] link_tgt,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jmp_tgt
);

  localparam int unsigned EXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W  = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [IMM_W-1:0] imm;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  br_off;
  logic [XLEN-1:0]  id_pc_plus;

  assign imm = id_instr[IMM_W-1:0];
  assign idx = id_instr[IDX_W-1:0];

  always_comb begin
    br_off     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    id_pc_plus = id_pc + STEP;
    seq_tgt    = fetch_pc + STEP;
    link_tgt   = id_pc_plus;
    br_tgt     = id_pc_plus + br_off;
    jmp_tgt    = {id_pc[XLEN-1 -: HI_W], idx, 2'b00};
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  npc_ctrl_t       ctrl,
  input  logic            ops_equal,
  input  logic            stall,
  input  logic [XLEN-1:0] seq_tgt,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output npc_src_e        src,
  output logic [XLEN-1:0] sel_pc,
  output logic            redirect
);

  logic br_taken;

  always_comb begin
    br_taken = (ctrl.beq & ops_equal) | (ctrl.bne & ~ops_equal);
    if (ctrl.jreg)                  src = SRC_REG;
    else if (ctrl.jmp | ctrl.jal)   src = SRC_JUMP;
    else if (br_taken)              src = SRC_BRANCH;
    else                            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_REG:    sel_pc = reg_tgt;
      SRC_JUMP:   sel_pc = jmp_tgt;
      SRC_BRANCH: sel_pc = br_tgt;
      default:    sel_pc = seq_tgt;
    endcase
  end

  assign redirect = (src != SRC_SEQ) & ~stall;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     IMM_W    = 16,
  parameter int unsigned     IDX_W    = 26,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic [XLEN-1:0] id_instr_i,
  input  logic            beq_i,
  input  logic            bne_i,
  input  logic            j_i,
  input  logic            jal_i,
  input  logic            jr_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] link_o
);

  localparam int unsigned HI_W = XLEN - IDX_W - 2;

  logic            rst_sync_n;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic            pc_en;
  npc_ctrl_t       ctrl;
  logic            ops_equal;
  logic [XLEN-1:0] seq_tgt, link_tgt, br_tgt, jmp_tgt, sel_pc;
  npc_src_e        src;
  logic            redirect;

  assign ctrl = '{beq: beq_i, bne: bne_i, jmp: j_i, jal: jal_i, jreg: jr_i};

  npc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .op_a  (op_a_i),
    .op_b  (op_b_i),
    .equal (ops_equal)
  );

  npc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_tgt (
    .fetch_pc (pc_q),
    .id_pc    (id_pc_i),
    .id_instr (id_instr_i),
    .seq_tgt  (seq_tgt),
    .link_tgt (link_tgt),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .ctrl      (ctrl),
    .ops_equal (ops_equal),
    .stall     (stall_i),
    .seq_tgt   (seq_tgt),
    .br_tgt    (br_tgt),
    .jmp_tgt   (jmp_tgt),
    .reg_tgt   (op_a_i),
    .src       (src),
    .sel_pc    (sel_pc),
    .redirect  (redirect)
  );

  // Next-state of the PC register
  always_comb begin
    pc_en = ~stall_i;
    pc_d  = pc_en ? sel_pc : pc_q;
  end

  // PC register with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= RESET_PC;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign next_pc_o  = pc_d;
  assign redirect_o = redirect;
  assign link_o     = link_tgt;

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_i |=> $stable(pc_q)) else $error("stall moved pc"); // R3

  AST_STALL_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_i |-> !redirect_o) else $error("redirect during stall"); // R3

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall_i && !redirect_o) |=> pc_q == $past(pc_q) + XLEN'(4)) else $error("seq step"); // R2

  AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect_o |=> pc_q == $past(next_pc_o)) else $error("redirect target not loaded"); // R10

  AST_JR_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (jr_i && !stall_i) |-> (redirect_o && next_pc_o == op_a_i)) else $error("jr priority"); // R8

  AST_JUMP_FIELDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((j_i || jal_i) && !jr_i && !stall_i) |->
      (next_pc_o[1:0] == 2'b00 && next_pc_o[XLEN-1 -: HI_W] == id_pc_i[XLEN-1 -: HI_W]))
    else $error("jump target fields"); // R7

  AST_BRANCH_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (redirect_o && !jr_i && !j_i && !jal_i) |->
      ((beq_i && op_a_i == op_b_i) || (bne_i && op_a_i != op_b_i))) else $error("spurious branch"); // R5

endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk;
  logic        rst_n;
  logic        stall_i;
  logic [31:0] id_pc_i, id_instr_i, op_a_i, op_b_i;
  logic        beq_i, bne_i, j_i, jal_i, jr_i;
  logic [31:0] pc_o, next_pc_o, link_o;
  logic        redirect_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model_pc;

  npc_unit #(.RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .id_pc_i(id_pc_i), .id_instr_i(id_instr_i),
    .beq_i(beq_i), .bne_i(bne_i), .j_i(j_i), .jal_i(jal_i), .jr_i(jr_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .redirect_o(redirect_o), .link_o(link_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Behavioural reference for the next address and the redirect flag
  function automatic logic [32:0] ref_next(input logic [31:0] pc);
    logic [31:0] off;
    logic [31:0] nxt;
    logic        red;
    off = {{14{id_instr_i[15]}}, id_instr_i[15:0], 2'b00};
    red = 1'b1;
    if (stall_i) begin
      nxt = pc; red = 1'b0;
    end else if (jr_i) nxt = op_a_i;
    else if (j_i || jal_i) nxt = {id_pc_i[31:28], id_instr_i[25:0], 2'b00};
    else if ((beq_i && op_a_i == op_b_i) || (bne_i && op_a_i != op_b_i))
      nxt = id_pc_i + 32'd4 + off;
    else begin
      nxt = pc + 32'd4; red = 1'b0;
    end
    return {red, nxt};
  endfunction

  // Drive one decode cycle at the falling edge, check outputs, then the PC after the edge
  task automatic step(input string req, input logic st, input logic [4:0] fl,
                      input logic [31:0] ipc, input logic [31:0] ins,
                      input logic [31:0] a, input logic [31:0] b);
    logic [32:0] e;
    @(negedge clk);
    stall_i = st; {beq_i, bne_i, j_i, jal_i, jr_i} = fl;
    id_pc_i = ipc; id_instr_i = ins; op_a_i = a; op_b_i = b;
    #1;
    e = ref_next(model_pc);
    check32({req, " next_pc"}, next_pc_o, e[31:0]);
    check32({req, " redirect"}, {31'd0, redirect_o}, {31'd0, e[32]});
    check32("R11 link", link_o, ipc + 32'd4);
    @(posedge clk); #1;
    model_pc = e[31:0];
    check32({req, " pc"}, pc_o, model_pc);
  endtask

  localparam logic [4:0] F_NONE = 5'b00000, F_BEQ = 5'b10000, F_BNE = 5'b01000,
                         F_J = 5'b00100, F_JAL = 5'b00010, F_JR = 5'b00001;

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall_i = 1'b1; {beq_i, bne_i, j_i, jal_i, jr_i} = F_NONE;
    id_pc_i = '0; id_instr_i = '0; op_a_i = '0; op_b_i = '0;
    model_pc = RST_PC;
    repeat (3) @(posedge clk);
    #1 check32("R1 reset pc", pc_o, RST_PC);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check32("R1 pc after release", pc_o, RST_PC);
    // R2 sequential fetch
    for (int i = 0; i < 4; i++)
      step("R2 seq", 1'b0, F_NONE, 32'h0040_0100 + 32'(i*4), 32'h1234_5678, 32'd1, 32'd2);
    // R4 beq taken, R5 bne taken and both not-taken cases
    step("R4 beq taken", 1'b0, F_BEQ, 32'h0040_0200, 32'h1000_0010, 32'hAA, 32'hAA);
    step("R5 beq not taken", 1'b0, F_BEQ, 32'h0040_0300, 32'h1000_0010, 32'hAA, 32'hAB);
    step("R5 bne taken", 1'b0, F_BNE, 32'h0040_0400, 32'h1400_0020, 32'h5, 32'h6);
    step("R5 bne not taken", 1'b0, F_BNE, 32'h0040_0500, 32'h1400_0020, 32'h7, 32'h7);
    // R6 negative offset
    step("R6 backward beq", 1'b0, F_BEQ, 32'h0040_0600, 32'h1000_FFF0, 32'h0, 32'h0);
    step("R6 offset -1", 1'b0, F_BNE, 32'h0040_0700, 32'h1400_FFFF, 32'h1, 32'h0);
    // R7 jumps, R8 register jump
    step("R7 j", 1'b0, F_J, 32'hA040_0800, 32'h0BFF_FFFF, 32'h0, 32'h0);
    step("R7 jal", 1'b0, F_JAL, 32'h5000_0000, 32'h0C00_1234, 32'h0, 32'h0);
    step("R8 jr", 1'b0, F_JR, 32'h0040_0900, 32'h03E0_0008, 32'hDEAD_BEE0, 32'h0);
    // R9 priority mixes
    step("R9 jr over j and beq", 1'b0, F_JR | F_J | F_BEQ, 32'h0040_0A00, 32'h0800_0100, 32'h0044_0000, 32'h0044_0000);
    step("R9 jal over bne", 1'b0, F_JAL | F_BNE, 32'h0040_0B00, 32'h0C00_0200, 32'h1, 32'h2);
    step("R9 branch over seq", 1'b0, F_BEQ | F_BNE, 32'h0040_0C00, 32'h1000_0004, 32'h3, 32'h4);
    // R3 stall with jumps in decode
    step("R3 stall jr", 1'b1, F_JR, 32'h0040_0D00, 32'h0, 32'h1111_0000, 32'h0);
    step("R3 stall beq", 1'b1, F_BEQ, 32'h0040_0D00, 32'h1000_0040, 32'h9, 32'h9);
    step("R3 stall none", 1'b1, F_NONE, 32'h0040_0D00, 32'h0, 32'h0, 32'h0);
    // R10 mixed traffic
    for (int i = 0; i < 80; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 2 == 0) ? a : $urandom;
      step("R10 mixed", ($urandom % 5 == 0), 5'($urandom), $urandom, $urandom, a, b);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule